// File: doc/BRIEF.md
# Dual Selectable Clock Divider with Freeze

The block takes one input clock and produces two divided clocks, `qa_o` and `qb_o`. Both are taken from a single shared up-counter, so every rising edge that the two outputs have in common happens on the same input clock edge. Each output has its own 2-bit ratio select. The A output reaches from divide-by-1 (the input clock itself) down to divide-by-8. The B output reaches from divide-by-2 down to divide-by-16. Every divided output has a 50% duty cycle.

A freeze control stops the divider without cutting any output pulse short. The control is captured on the falling edge of the input clock, so the counter and the divide-by-1 path are gated only while the input clock is low. While frozen, every output holds its level. On release the count resumes from where it stopped, with its phase kept. An active-low master reset clears the divider at once. After reset is released, every output goes high on the first rising edge of the input clock. This lets several dividers be brought into step by one common reset.

The select inputs are quasi-static. They are meant to change only during reset or while the divider is frozen. A new select value shows at the output at once, as a different tap of the same counter.

Top module: `dual_clkdiv`

## Requirements
- R1: With `qa_sel` = 0, `qa_o` follows the input clock. Values 1, 2 and 3 give divide-by-2, divide-by-4 and divide-by-8. The select value is read as an unsigned number.
- R2: `qb_sel` values 0, 1, 2 and 3 give divide-by-2, 4, 8 and 16 on `qb_o`. Each divided output is high for the first half of its period, counted from reset release, and low for the second half.
- R3: Whenever the slower of the two outputs has a rising edge, the faster output has a rising edge on the same input clock edge.
- R4: `frz_en` is sampled on the falling edge of `clk_in`. Rising edges after a high sample do not advance the divider, and both outputs hold their level.
- R5: While frozen, the divide-by-1 output stays low. No output ever shows a high or low pulse shorter than half an input clock period, including around a freeze or a release.
- R6: After `frz_en` is sampled low again, the divider resumes from its held count. The next state is the one that would have followed had the freeze not happened.
- R7: While `mrst_n` is low, both outputs are low at once, without waiting for a clock edge. The divider count is cleared.
- R8: After `mrst_n` rises, both outputs go high on the first rising edge of `clk_in`.
- R9: A select change made while the divider is frozen takes effect at once. The output becomes the matching tap of the held count, and the output continues from that phase after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock to be divided |
| mrst_n | input | 1 | Master reset, active low, asynchronous assertion |
| frz_en | input | 1 | Freeze request, sampled on the falling clock edge |
| qa_sel | input | 2 | Ratio select for `qa_o` (0: /1, 1: /2, 2: /4, 3: /8) |
| qb_sel | input | 2 | Ratio select for `qb_o` (0: /2, 1: /4, 2: /8, 3: /16) |
| qa_o | output | 1 | Divided clock A |
| qb_o | output | 1 | Divided clock B |

## Verification
A wrong counter bit or an increment that is skipped shows at the ports as a wrong output level. It appears within one period of the selected ratio, at most 16 input cycles. Comparing every output at both clock phases against a count of the rising edges since reset release therefore catches it quickly. A freeze that is captured on the wrong edge, or that leaks, shows within one cycle. A leak breaks the held level, and capture on the rising edge produces a shortened pulse on the divide-by-1 output, which a pulse-width monitor catches. A reset that is not asynchronous, or an output that does not come up high on the first edge after release, shows within a fraction of a cycle.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
// Package: clkdiv_pkg
// Shared sizes and types for the dual clock divider.
// Assumes a 2-bit select per output and a counter wide enough to give
// every tap that the slower output can select.
package clkdiv_pkg;
    localparam int DIV_CNT_W = 4;            // counter bits, bit k gives /2^(k+1)
    localparam int DIV_SEL_W = 2;            // select width per output
    localparam int DIV_NSRC  = 1 << DIV_SEL_W;

    typedef logic [DIV_SEL_W-1:0] div_sel_t;
endpackage

// File: rtl/clkdiv_freeze_capture.sv
`timescale 1ns/1ps
// Module: clkdiv_freeze_capture
// Samples the freeze request on the falling edge of the input clock. The
// divider is therefore gated only while the clock is low, so no runt pulse
// can form. Assumes frz_en_i meets setup to the falling edge.
module clkdiv_freeze_capture (
    input  logic clk_in,
    input  logic mrst_n,
    input  logic frz_en_i,
    output logic frz_o
);
    // Purpose: falling-edge capture of the freeze request, cleared by master reset.
    always_ff @(negedge clk_in or negedge mrst_n) begin
        if (!mrst_n) begin
            frz_o <= 1'b0;
        end else begin
            frz_o <= frz_en_i;
        end
    end
endmodule

// File: rtl/clkdiv_counter.sv
`timescale 1ns/1ps
// Module: clkdiv_counter
// Shared up-counter behind every divided output. Reset loads all ones, so
// the first rising edge after release wraps to zero and every tap (the
// inverted counter bits) goes high on that edge. Assumes run_i changes
// only while the clock is low.
module clkdiv_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk_in,
    input  logic             mrst_n,
    input  logic             run_i,
    output logic [CNT_W-1:0] taps_o
);
    localparam logic [CNT_W-1:0] CNT_RST = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;

    // Purpose: advance the count on each rising edge that is not frozen.
    always_ff @(posedge clk_in or negedge mrst_n) begin
        if (!mrst_n) begin
            cnt_q <= CNT_RST;
        end else if (run_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Purpose: taps are high for the first half of each period.
    always_comb begin
        taps_o = ~cnt_q;
    end
endmodule

// File: rtl/clkdiv_tap_select.sv
`timescale 1ns/1ps
// Module: clkdiv_tap_select
// Picks one source for a divided output. With BYPASS set, source 0 is the
// gated input clock and source i is tap i-1. Otherwise source i is tap i.
// Assumes sel_i is quasi-static (it changes only in reset or during a freeze).
module clkdiv_tap_select #(
    parameter int CNT_W  = 4,
    parameter int SEL_W  = 2,
    parameter bit BYPASS = 1'b0
) (
    input  logic [CNT_W-1:0] taps_i,
    input  logic             gclk_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             q_o
);
    localparam int NSRC = 1 << SEL_W;

    logic [NSRC-1:0] src;

    generate
        if (BYPASS) begin : g_bypass
            assign src[0] = gclk_i;
            for (genvar i = 1; i < NSRC; i++) begin : g_src
                assign src[i] = taps_i[i-1];
            end
        end else begin : g_taps
            for (genvar i = 0; i < NSRC; i++) begin : g_src
                assign src[i] = taps_i[i];
            end
        end
    endgenerate

    // Purpose: route the selected source to the output.
    always_comb begin
        q_o = src[sel_i];
    end
endmodule

// File: rtl/dual_clkdiv.sv
`timescale 1ns/1ps
// Module: dual_clkdiv
// Two divided clocks taken from one shared counter, with falling-edge
// freeze and an asynchronous active-low master reset. Output A offers
// /1,/2,/4,/8 and output B offers /2,/4,/8,/16. Assumes selects are
// quasi-static and that the freeze request is synchronous to clk_in.
module dual_clkdiv
    import clkdiv_pkg::*;
#(
    parameter int CNT_W = DIV_CNT_W,
    parameter int SEL_W = DIV_SEL_W
) (
    input  logic             clk_in,
    input  logic             mrst_n,
    input  logic             frz_en,
    input  logic [SEL_W-1:0] qa_sel,
    input  logic [SEL_W-1:0] qb_sel,
    output logic             qa_o,
    output logic             qb_o
);
    logic             frz_q;
    logic             gclk;
    logic [CNT_W-1:0] taps;

    clkdiv_freeze_capture u_frz (
        .clk_in   (clk_in),
        .mrst_n   (mrst_n),
        .frz_en_i (frz_en),
        .frz_o    (frz_q)
    );

    clkdiv_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk_in (clk_in),
        .mrst_n (mrst_n),
        .run_i  (!frz_q),
        .taps_o (taps)
    );

    // Purpose: divide-by-1 path, gated only while the clock is low.
    always_comb begin
        gclk = clk_in & ~frz_q & mrst_n;
    end

    clkdiv_tap_select #(.CNT_W(CNT_W), .SEL_W(SEL_W), .BYPASS(1'b1)) u_sel_a (
        .taps_i (taps),
        .gclk_i (gclk),
        .sel_i  (qa_sel),
        .q_o    (qa_o)
    );

    clkdiv_tap_select #(.CNT_W(CNT_W), .SEL_W(SEL_W), .BYPASS(1'b0)) u_sel_b (
        .taps_i (taps),
        .gclk_i (gclk),
        .sel_i  (qb_sel),
        .q_o    (qb_o)
    );

    // ---------------- assertions ----------------
    // R2: in /2 mode, an unfrozen edge toggles B (unless the select moved).
    a_r2_div2_toggle: assert property (@(posedge clk_in) disable iff (!mrst_n)
        (!frz_q && qb_sel == '0) |=> ((qb_o != $past(qb_o)) || (qb_sel != $past(qb_sel))));

    // R3: when B rises, an A output no slower than B rises with it.
    a_r3_edge_aligned: assert property (@(posedge clk_in) disable iff (!mrst_n)
        ($rose(qb_o) && $stable(qb_sel) && $stable(qa_sel) && qa_sel != '0
         && ({1'b0, qa_sel} <= ({1'b0, qb_sel} + 1'b1))) |-> qa_o);

    // R4: a frozen edge leaves B unchanged (unless the select moved).
    a_r4_freeze_hold: assert property (@(posedge clk_in) disable iff (!mrst_n)
        frz_q |=> ((qb_o == $past(qb_o)) || (qb_sel != $past(qb_sel))));

    // R5: the divide-by-1 output stays low through a frozen high phase.
    a_r5_div1_held: assert property (@(negedge clk_in) disable iff (!mrst_n)
        (frz_q && qa_sel == '0) |-> !qa_o);

    // R7: both outputs are low during master reset.
    always @(negedge clk_in) begin
        if (!mrst_n) begin
            a_r7_reset_low: assert (!qa_o && !qb_o);
        end
    end
endmodule

// File: tb/tb_dual_clkdiv.sv
`timescale 1ns/1ps
module tb_dual_clkdiv;
    logic       clk = 1'b0;
    logic       mr_n = 1'b0;
    logic       en = 1'b0;
    logic [1:0] sa = 2'd0;
    logic [1:0] sb = 2'd0;
    logic       qa;
    logic       qb;

    int checks = 0;
    int errors = 0;
    int adv = 0;
    bit ref_frz = 1'b0;
    bit mon_on = 1'b0;
    int runts = 0;
    realtime qa_t = 0.0;
    realtime qb_t = 0.0;

    always #2.5 clk = ~clk;    // 200 MHz

    dual_clkdiv dut (
        .clk_in (clk),
        .mrst_n (mr_n),
        .frz_en (en),
        .qa_sel (sa),
        .qb_sel (sb),
        .qa_o   (qa),
        .qb_o   (qb)
    );

    // R5 pulse-width monitors: a pulse shorter than half a period is a runt.
    always @(qa) begin
        if (mon_on && (($realtime - qa_t) < 2.4)) runts++;
        qa_t = $realtime;
    end
    always @(qb) begin
        if (mon_on && (($realtime - qb_t) < 2.4)) runts++;
        qb_t = $realtime;
    end

    // Expected tap k level after a advances since reset release.
    function automatic bit exp_tap(int a, int k);
        return (a > 0) && (((a - 1) % (2 << k)) < (1 << k));
    endfunction

    function automatic bit exp_qa(bit high_phase);
        if (sa == 2'd0) return high_phase && (adv > 0) && !ref_frz && mr_n;
        return exp_tap(adv, int'(sa) - 1);
    endfunction

    function automatic bit exp_qb();
        return exp_tap(adv, int'(sb));
    endfunction

    task automatic check(bit act, bit exp, string req, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0b expected %0b (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    // One input clock period, checking both outputs in both phases.
    task automatic step(string ra, string rb);
        @(posedge clk);
        if (!ref_frz) adv++;
        #1;
        check(qa, exp_qa(1'b1), ra, "qa high phase");
        check(qb, exp_qb(), rb, "qb high phase");
        @(negedge clk);
        ref_frz = en;
        #1;
        check(qa, exp_qa(1'b0), ra, "qa low phase");
        check(qb, exp_qb(), rb, "qb low phase");
    endtask

    // Reset with given selects, then release in the low phase.
    task automatic start(logic [1:0] a_v, logic [1:0] b_v);
        mon_on = 1'b0;
        mr_n = 1'b0;
        en = 1'b0;
        sa = a_v;
        sb = b_v;
        @(negedge clk);
        #1;
        adv = 0;
        ref_frz = 1'b0;
        check(qa, 1'b0, "R7", "qa in reset");
        check(qb, 1'b0, "R7", "qb in reset");
        mr_n = 1'b1;
        step("R8", "R8");
        mon_on = 1'b1;
    endtask

    task automatic t_reset_state();
        mr_n = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        check(qa, 1'b0, "R7", "reset state qa low phase");
        check(qb, 1'b0, "R7", "reset state qb low phase");
        @(posedge clk);
        #1;
        check(qa, 1'b0, "R7", "reset state qa high phase");
        check(qb, 1'b0, "R7", "reset state qb high phase");
    endtask

    task automatic t_sweep();
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                start(2'(a), 2'(b));
                repeat (36) step("R1", "R2");
            end
        end
    endtask

    task automatic t_align();
        bit prev_qb;
        start(2'd1, 2'd3);
        prev_qb = qb;
        for (int i = 0; i < 40; i++) begin
            step("R3", "R3");
            if (qb && !prev_qb) check(qa, 1'b1, "R3", "qa high when qb rises");
            prev_qb = qb;
        end
    endtask

    task automatic t_freeze();
        bit hold_b;
        start(2'd0, 2'd1);
        repeat (5) step("R1", "R2");
        en = 1'b1;
        step("R4", "R4");
        hold_b = qb;
        for (int i = 0; i < 6; i++) begin
            step("R5", "R4");
            check(qb, hold_b, "R4", "qb held while frozen");
        end
        en = 1'b0;
        repeat (12) step("R6", "R6");
    endtask

    task automatic t_sel_frozen();
        start(2'd2, 2'd1);
        repeat (7) step("R1", "R2");
        en = 1'b1;
        repeat (2) step("R4", "R4");
        sa = 2'd3;
        sb = 2'd3;
        #0.5;
        check(qa, exp_qa(1'b0), "R9", "qa after select change");
        check(qb, exp_qb(), "R9", "qb after select change");
        repeat (2) step("R9", "R9");
        en = 1'b0;
        repeat (20) step("R9", "R9");
    endtask

    task automatic t_async();
        start(2'd1, 2'd2);
        repeat (5) step("R1", "R2");
        @(posedge clk);
        #1;
        mon_on = 1'b0;
        mr_n = 1'b0;
        #0.3;
        check(qa, 1'b0, "R7", "qa low immediately on reset");
        check(qb, 1'b0, "R7", "qb low immediately on reset");
    endtask

    task automatic t_runt();
        mon_on = 1'b0;
        checks++;
        if (runts != 0) begin
            errors++;
            $display("FAIL R5 runt pulses: got %0d expected 0", runts);
        end
    endtask

    initial begin
        t_reset_state();
        t_sweep();
        t_align();
        t_freeze();
        t_sel_frozen();
        t_async();
        t_runt();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5.0);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule